// File: doc/BRIEF.md
# Double-Edge Strobe Data-Out Transmitter

This block is the host-side sender for a burst of 16-bit words on a source-synchronous link where the strobe line toggles once per word. Both directions of toggle count. Words arrive on a ready/valid stream. The block places each word on the parallel bus, waits out a setup time, toggles the strobe, and then keeps the word on the bus for a hold time before it moves the next word in. It also enforces a minimum spacing between edges.

The setup, hold and cycle times are cycle counts on configuration inputs. They are captured, together with the word count, when `start` is pulsed. The device throttles the burst through an active-low ready line. That line passes through a two-flop synchronizer, and it is checked before every edge. When the device asserts ready again, edges resume from the current strobe level. A one-cycle `done` pulse follows the hold time of the last word, and the strobe is left at its final level.

Top module: `udma_out_tx`

## Requirements
- R1: After reset, `strobe`, `bus_data`, `busy`, `done` and `in_ready` are all 0.
- R2: Each strobe transition, rising or falling, carries exactly one accepted input word, in acceptance order. A burst of N words makes exactly N transitions, so the final strobe level is the starting level XOR (N mod 2).
- R3: `bus_data` holds steady for at least `cfg_setup` cycles before every strobe transition.
- R4: `bus_data` does not change for at least `cfg_hold` cycles after a strobe transition.
- R5: Two strobe transitions are at least P = max(`cfg_cycle`, `cfg_setup`+`cfg_hold`) cycles apart. With setup and hold of at least 1, input always valid and the device ready, the spacing is exactly P.
- R6: Once `dev_rdy_n` has been sampled high on a rising clock edge, the strobe can toggle at most once more, no later than the following edge. No further transition happens while the line stays high.
- R7: When `dev_rdy_n` returns low after a pause, transitions resume with no extra edge, and the word order continues unbroken.
- R8: `done` is high for exactly one cycle, max(`cfg_hold`,1) cycles after the final transition. `busy` is low in that cycle and the strobe keeps its level.
- R9: A burst with a word count of 0 raises `done` without any strobe transition and without asserting `in_ready`.
- R10: The configuration and word count are sampled only at `start` while idle. Changing them, or pulsing `start`, during a burst has no effect on that burst.
- R11: `in_ready` is high only between transitions, once the hold time has passed and words remain to be sent. A word is accepted when `in_valid` and `in_ready` are both high on a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a burst when idle |
| word_count | input | NW | Number of words in the burst |
| cfg_setup | input | CW | Setup time in cycles |
| cfg_hold | input | CW | Hold time in cycles |
| cfg_cycle | input | CW | Minimum edge-to-edge time in cycles |
| in_valid | input | 1 | Input word valid |
| in_data | input | DW | Input word |
| in_ready | output | 1 | Block accepts a word |
| dev_rdy_n | input | 1 | Device ready, active low, asynchronous |
| bus_data | output | DW | Parallel data bus |
| strobe | output | 1 | Double-edge data strobe |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle end-of-burst pulse |

## Verification
A device pause can arrive in the same cycle in which the transmitter has already decided to fire an edge. The synchronizer delay then lets one last edge through after the pause has been sampled. The bench raises `dev_rdy_n` at several points in a running burst, some of them just before an edge is due. The scoreboard accepts a transition only up to the second sampled edge after the rise, and counts every later one as a failure. Word order and the total edge count across the resume are also judged against the queue of accepted words.

// File: rtl/udma_out_tx.sv
module udma_out_tx #(
  parameter int DW = 16,
  parameter int CW = 8,
  parameter int NW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] word_count,
  input  logic [CW-1:0] cfg_setup,
  input  logic [CW-1:0] cfg_hold,
  input  logic [CW-1:0] cfg_cycle,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  input  logic          dev_rdy_n,
  output logic [DW-1:0] bus_data,
  output logic          strobe,
  output logic          busy,
  output logic          done
);
  localparam int TW = CW + 1;
  localparam logic [TW-1:0] TMAX = {TW{1'b1}};

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_ARM} st_t;

  st_t           st;
  logic [TW-1:0] setup_q, hold_q, period_q, stab, since;
  logic [NW-1:0] rem;
  logic [1:0]    sync;
  logic [DW-1:0] data_q;
  logic          stb_q, done_q;

  logic [TW-1:0] sum_in;
  logic [TW-1:0] per_in;
  logic          rdy_s, hold_ok, take, fire, finish;

  assign sum_in  = {1'b0, cfg_setup} + {1'b0, cfg_hold};
  assign per_in  = (sum_in > {1'b0, cfg_cycle}) ? sum_in : {1'b0, cfg_cycle};
  assign rdy_s   = ~sync[1];
  assign hold_ok = since >= hold_q;
  assign in_ready = (st == S_FETCH) && (rem != '0) && hold_ok;
  assign take    = in_ready && in_valid;
  assign fire    = (st == S_ARM) && (stab >= setup_q) && (since >= period_q) && rdy_s;
  assign finish  = (st == S_FETCH) && (rem == '0) && hold_ok;

  assign bus_data = data_q;
  assign strobe   = stb_q;
  assign busy     = (st != S_IDLE);
  assign done     = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      setup_q  <= '0;
      hold_q   <= '0;
      period_q <= '0;
      stab     <= TMAX;
      since    <= TMAX;
      rem      <= '0;
      sync     <= 2'b11;
      data_q   <= '0;
      stb_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      sync   <= {sync[0], dev_rdy_n};
      done_q <= finish;
      stab   <= take ? TW'(1) : ((stab == TMAX) ? stab : stab + TW'(1));
      since  <= fire ? TW'(1) : ((since == TMAX) ? since : since + TW'(1));
      case (st)
        S_IDLE: if (start) begin
          setup_q  <= {1'b0, cfg_setup};
          hold_q   <= {1'b0, cfg_hold};
          period_q <= per_in;
          rem      <= word_count;
          since    <= TMAX;
          st       <= S_FETCH;
        end
        S_FETCH: begin
          if (finish) st <= S_IDLE;
          else if (take) begin
            data_q <= in_data;
            st     <= S_ARM;
          end
        end
        S_ARM: if (fire) begin
          stb_q <= ~stb_q;
          rem   <= rem - NW'(1);
          st    <= S_FETCH;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // Port-level watchers feeding the timing properties
  logic [DW-1:0] w_bus;
  logic          w_stb;
  logic [15:0]   w_stab, w_since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_bus   <= '0;
      w_stb   <= 1'b0;
      w_stab  <= 16'hFFFF;
      w_since <= 16'hFFFF;
    end else begin
      w_bus   <= bus_data;
      w_stb   <= strobe;
      w_stab  <= (bus_data != w_bus) ? 16'd1 : ((w_stab == 16'hFFFF) ? w_stab : w_stab + 16'd1);
      w_since <= (strobe != w_stb) ? 16'd1 : ((w_since == 16'hFFFF) ? w_since : w_since + 16'd1);
    end
  end

  p_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe != w_stb) |-> (w_stab >= 16'(setup_q)));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_data != w_bus) |-> (w_since >= 16'(hold_q)));

  p_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe != w_stb) |-> (w_since >= 16'(period_q)));

  p_pause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rdy_n && $past(dev_rdy_n) && $past(dev_rdy_n, 2) && $past(dev_rdy_n, 3))
      |-> (strobe == $past(strobe)));

  p_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $stable(strobe)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy);
endmodule

// File: tb/test_udma_out_tx.sv
`timescale 1ns/1ps
module test_udma_out_tx;
  localparam int DW = 16, CW = 8, NW = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [NW-1:0] word_count = '0;
  logic [CW-1:0] cfg_setup = '0, cfg_hold = '0, cfg_cycle = '0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, dev_rdy_n = 1'b0;
  logic [DW-1:0] bus_data;
  logic strobe, busy, done;

  udma_out_tx #(.DW(DW), .CW(CW), .NW(NW)) i_udma_out_tx (
    .clk(clk), .rst_n(rst_n), .start(start), .word_count(word_count),
    .cfg_setup(cfg_setup), .cfg_hold(cfg_hold), .cfg_cycle(cfg_cycle),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .dev_rdy_n(dev_rdy_n), .bus_data(bus_data), .strobe(strobe),
    .busy(busy), .done(done));

  always #2.5 clk = ~clk;

  int errs = 0, checks = 0;
  logic [DW-1:0] exp_q[$];
  int b_s, b_h, b_c, b_p;
  bit tight = 0, paused = 0, saw_ready = 0, done_seen = 0;
  int burst_edges = 0, cyc = 0, last_edge = 0, last_data = 0, rdy_cnt = 0;
  logic prev_stb = 0, prev_done = 0;
  logic [DW-1:0] prev_bus = '0;
  logic [DW-1:0] seed = 16'h1357;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      logic [DW-1:0] e;
      cyc++;
      rdy_cnt = dev_rdy_n ? rdy_cnt + 1 : 0;
      if (in_ready) saw_ready = 1;
      if (bus_data != prev_bus) begin
        if (burst_edges > 0) chk(cyc - last_edge >= b_h, "R4 hold", cyc - last_edge, b_h);
        last_data = cyc;
      end
      if (strobe != prev_stb) begin
        chk(rdy_cnt < 3, "R6 edge during pause", rdy_cnt, 2);
        chk(cyc - last_data >= b_s, "R3 setup", cyc - last_data, b_s);
        if (burst_edges > 0) begin
          chk(cyc - last_edge >= b_p, "R5 spacing", cyc - last_edge, b_p);
          if (tight && !paused) chk(cyc - last_edge == b_p, "R5 exact period", cyc - last_edge, b_p);
        end
        if (exp_q.size() == 0) chk(0, "R2 edge without word", 1, 0);
        else begin
          e = exp_q.pop_front();
          chk(bus_data == e, "R2 word order", bus_data, e);
        end
        burst_edges++;
        last_edge = cyc;
      end
      if (done) begin
        int hh;
        hh = (b_h > 1) ? b_h : 1;
        chk(!busy, "R8 busy low at done", busy, 0);
        chk(strobe == prev_stb, "R8 strobe kept", strobe, prev_stb);
        if (burst_edges > 0) chk(cyc - last_edge == hh, "R8 done delay", cyc - last_edge, hh);
        done_seen = 1;
      end
      if (prev_done) chk(!done, "R8 done one cycle", done, 0);
      prev_done = done;
      prev_stb = strobe;
      prev_bus = bus_data;
    end
  end

  task automatic push_word(input int gap);
    logic [DW-1:0] d;
    seed = seed * 16'd75 + 16'd74;
    d = seed;
    if (d == prev_bus) d = ~d;
    repeat (gap) @(negedge clk);
    in_valid = 1; in_data = d;
    while (!in_ready) @(negedge clk);
    exp_q.push_back(d);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic run_burst(input int n, input int s, input int h, input int c,
                           input int gap, input bit tgt);
    logic lvl;
    b_s = s; b_h = h; b_c = c;
    b_p = (s + h > c) ? s + h : c;
    tight = tgt; paused = 0; saw_ready = 0; done_seen = 0; burst_edges = 0;
    lvl = strobe;
    @(negedge clk);
    start = 1; word_count = NW'(n);
    cfg_setup = CW'(s); cfg_hold = CW'(h); cfg_cycle = CW'(c);
    @(negedge clk);
    start = 0;
    for (int i = 0; i < n; i++) push_word(gap);
    while (!done_seen) @(negedge clk);
    chk(burst_edges == n, "R2 edge count", burst_edges, n);
    chk(exp_q.size() == 0, "R2 words left", exp_q.size(), 0);
    chk(strobe == (lvl ^ n[0]), "R2 final level", strobe, lvl ^ n[0]);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(strobe == 0 && bus_data == 0, "R1 reset outputs", {strobe, bus_data}, 0);
    chk(!busy && !done && !in_ready, "R1 reset flags", {busy, done, in_ready}, 0);
    rst_n = 1;
    @(negedge clk);

    run_burst(8, 2, 1, 5, 0, 1);
    run_burst(7, 3, 4, 2, 0, 1);
    run_burst(9, 1, 1, 1, 0, 1);
    run_burst(10, 1, 2, 2, 2, 0);   // stalled input, R11

    fork
      run_burst(12, 1, 2, 3, 0, 0);
      begin
        paused = 1;
        repeat (9) @(negedge clk);
        dev_rdy_n = 1;
        repeat (15) @(negedge clk);
        dev_rdy_n = 0;              // R7 resume
        repeat (11) @(negedge clk);
        dev_rdy_n = 1;
        repeat (6) @(negedge clk);
        dev_rdy_n = 0;
      end
    join

    run_burst(0, 2, 3, 4, 0, 0);    // R9
    chk(!saw_ready, "R9 no in_ready", saw_ready, 0);
    chk(burst_edges == 0, "R9 no edges", burst_edges, 0);

    fork                            // R10
      run_burst(6, 2, 2, 6, 0, 1);
      begin
        repeat (8) @(negedge clk);
        start = 1; word_count = 16'd3;
        cfg_setup = 1; cfg_hold = 1; cfg_cycle = 1;
        @(negedge clk);
        start = 0;
      end
    join

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule